// File: doc/BRIEF.md
# Serial Receiver with Sticky Status Flags

This block turns an oversampled asynchronous serial line into 8-bit characters. Each character is sent least significant bit first. Framing can be 8N1, 8 data bits plus a parity bit, or 8 data bits plus an address marker bit for multiprocessor links. The last completed character sits in a one-entry data register. Error conditions collect in sticky flags: framing, parity, break and overrun. Software reaches these through a small strobe-based read port.

Reading the data register clears the error flags, with one exception. An overrun that software has not yet seen in a primary status read stays set through the data read. It therefore cannot vanish in the gap between polling the status and fetching the character.

A secondary status register holds event bits that clear when that register is read. Every read returns the value captured on the first cycle of the access, however long the strobe is held.

Top module: `srx_receiver`

## Requirements
- R1: A frame consists of a low start bit, 8 data bits sent LSB first, an optional extra bit and a stop bit, each lasting OS_RATE ticks. After a frame, reading select 0 returns the character, and primary status (select 1) bit 0 (data available) reads 1.
- R2: A start is accepted only if the line is still low at the mid-bit sample. A rejected start loads no character and sets secondary status (select 2) bit 1.
- R3: With parity enabled and multiprocessor mode off, one parity bit follows the data. Polarity 0 means even, so the total count of ones is even; polarity 1 means odd. A mismatch sets primary status bit 3.
- R4: In multiprocessor mode the bit after the data is an address marker and is never a parity bit, even when parity is enabled. The marker is shown in primary status bit 5, and an address character sets secondary status bit 0.
- R5: If the line is low at the stop-bit sample, primary status bit 2 (framing) is set.
- R6: If all data bits are zero and the stop sample is low, primary status bit 4 (break) is set, together with the framing flag.
- R7: A character that completes while data available is still set raises primary status bit 1 (overrun) and replaces the held character.
- R8: A data read clears data available, framing, parity and break. It clears overrun only if a primary status read has returned that overrun since it was last raised.
- R9: A read access starts on the rising edge of rd_stb. rd_data takes the selected register value one cycle later and holds it unchanged while rd_stb stays high. Clear-on-read effects happen once per access.
- R10: Secondary status bits clear when select 2 is read. An event in the same cycle as that read keeps its bit set. Select 3 reads 0.
- R11: irq is high exactly when data available, overrun, framing, parity or break is set.
- R12: After reset all flags are 0, rd_data is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OS_RATE ticks per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity polarity, 1 = odd |
| cfg_mp_en | input | 1 | Multiprocessor (address marker) mode |
| rd_stb | input | 1 | Read access strobe, may be held |
| rd_sel | input | 2 | 0 data, 1 primary status, 2 secondary status |
| rd_data | output | 8 | Value captured at access start |
| irq | output | 1 | Receive interrupt request |

## Verification
The receiver is driven with clean characters and then with characters carrying correct and wrong parity under both polarities. This shows that the parity check follows the polarity setting rather than a fixed rule. Address-marker frames are sent with parity still enabled; they confirm that the ninth bit is taken as a marker and never judged as parity. Frames with a low stop bit, one with nonzero data and one with all-zero data, separate framing from break. A character landing between a status read and a data read shows an overrun surviving the data read and then clearing once it has been reported. A short low glitch on an idle line shows that a start is rejected without loading a character.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP,
        ST_WAIT_HI
    } srx_state_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          fe;
        logic          pe;
        logic          brk;
        logic          addr;
    } srx_frame_t;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ST0  = 2'd1,
        SEL_ST1  = 2'd2,
        SEL_NONE = 2'd3
    } srx_sel_t;

    // Parity error: total ones of data plus parity bit must match polarity
    function automatic logic par_bad(input logic [DW-1:0] d, input logic pbit,
                                     input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxs,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_mp_en,
    output logic       frm_valid,
    output srx_frame_t frm,
    output logic       glitch,
    output logic       busy
);
    localparam int CW   = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;
    localparam int BW   = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);
    localparam logic [CW-1:0] MID  = CW'(OS_RATE / 2 - 1);
    localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);

    srx_state_t      st;
    logic [CW-1:0]   cnt;
    logic [BW-1:0]   bitn;
    logic [DW-1:0]   shreg;
    logic            xbit;
    logic            mp_l, par_l, odd_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            xbit      <= 1'b0;
            mp_l      <= 1'b0;
            par_l     <= 1'b0;
            odd_l     <= 1'b0;
            frm_valid <= 1'b0;
            frm       <= '0;
            glitch    <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            glitch    <= 1'b0;
            if (os_tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!rxs) begin
                            st    <= ST_START;
                            cnt   <= '0;
                            mp_l  <= cfg_mp_en;
                            par_l <= cfg_par_en & ~cfg_mp_en;
                            odd_l <= cfg_par_odd;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!rxs) begin
                                st   <= ST_DATA;
                                bitn <= '0;
                            end else begin
                                st     <= ST_IDLE;
                                glitch <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rxs, shreg[DW-1:1]};
                            if (bitn == LASTBIT) begin
                                st   <= (mp_l || par_l) ? ST_EXTRA : ST_STOP;
                                xbit <= 1'b0;
                            end else begin
                                bitn <= bitn + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_EXTRA: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            xbit <= rxs;
                            st   <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            frm_valid <= 1'b1;
                            frm.data  <= shreg;
                            frm.fe    <= ~rxs;
                            frm.pe    <= par_l & par_bad(shreg, xbit, odd_l);
                            frm.brk   <= ~rxs & (shreg == '0);
                            frm.addr  <= mp_l & xbit;
                            st        <= rxs ? ST_IDLE : ST_WAIT_HI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_WAIT_HI: begin
                        if (rxs) st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign busy = (st != ST_IDLE);

    // R5: a completed frame only comes out of the stop-bit sample
    a_r5_frame_from_stop: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> $past(st == ST_STOP));

    // R2: a rejected start only comes from the start-validation state
    a_r2_glitch_from_start: assert property (@(posedge clk) disable iff (rst)
        glitch |-> $past(st == ST_START));

    // R4: a frame taken in multiprocessor mode never reports a parity error
    a_r4_mp_no_parity: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && $past(mp_l)) |-> !frm.pe);
endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_valid,
    input  srx_frame_t frm,
    input  logic       glitch,
    input  logic       busy,
    input  logic       rd_stb,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       irq
);
    logic [DW-1:0] data_q;
    logic dav, ovr, fe, pe, brk, addr_mk, ovr_unrep;
    logic s1_addr, s1_glitch;
    logic stb_q;

    logic rd_start, dread, s0read, s1read, ovr_evt;
    logic [7:0] st0_val, st1_val;

    assign rd_start = rd_stb & ~stb_q;
    assign dread    = rd_start & (srx_sel_t'(rd_sel) == SEL_DATA);
    assign s0read   = rd_start & (srx_sel_t'(rd_sel) == SEL_ST0);
    assign s1read   = rd_start & (srx_sel_t'(rd_sel) == SEL_ST1);
    assign ovr_evt  = frm_valid & dav & ~dread;

    assign st0_val = {1'b0, busy, addr_mk, brk, pe, fe, ovr, dav};
    assign st1_val = {6'b0, s1_glitch, s1_addr};

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            dav       <= 1'b0;
            ovr       <= 1'b0;
            fe        <= 1'b0;
            pe        <= 1'b0;
            brk       <= 1'b0;
            addr_mk   <= 1'b0;
            ovr_unrep <= 1'b0;
            s1_addr   <= 1'b0;
            s1_glitch <= 1'b0;
            stb_q     <= 1'b0;
            rd_data   <= '0;
        end else begin
            stb_q <= rd_stb;

            dav <= (dav & ~dread) | frm_valid;
            fe  <= (fe  & ~dread) | (frm_valid & frm.fe);
            pe  <= (pe  & ~dread) | (frm_valid & frm.pe);
            brk <= (brk & ~dread) | (frm_valid & frm.brk);

            if (frm_valid) begin
                data_q  <= frm.data;
                addr_mk <= frm.addr;
            end

            ovr       <= (ovr & ~(dread & ~ovr_unrep)) | ovr_evt;
            ovr_unrep <= (ovr_unrep & ~s0read) | ovr_evt;

            s1_addr   <= (s1_addr   & ~s1read) | (frm_valid & frm.addr);
            s1_glitch <= (s1_glitch & ~s1read) | glitch;

            if (rd_start) begin
                case (srx_sel_t'(rd_sel))
                    SEL_DATA: rd_data <= data_q;
                    SEL_ST0:  rd_data <= st0_val;
                    SEL_ST1:  rd_data <= st1_val;
                    default:  rd_data <= '0;
                endcase
            end
        end
    end

    assign irq = dav | ovr | fe | pe | brk;

    // R7: overrun can only rise while a character was waiting unread
    a_r7_ovr_needs_dav: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(dav));

    // R8: an unreported overrun survives the data read
    a_r8_ovr_kept: assert property (@(posedge clk) disable iff (rst)
        (dread && ovr && ovr_unrep) |=> ovr);

    // R8: data read with no new character empties the data register
    a_r8_dav_cleared: assert property (@(posedge clk) disable iff (rst)
        (dread && !frm_valid) |=> !dav && !fe && !pe && !brk);

    // R9: a held access keeps the captured value
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !rd_start) |=> $stable(rd_data));

    // R10: secondary read with no event in that cycle leaves it empty
    a_r10_st1_clear: assert property (@(posedge clk) disable iff (rst)
        (s1read && !glitch && !frm_valid) |=> (st1_val == 8'h00));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
    import srx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_mp_en,
    input  logic       rd_stb,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       irq
);
    logic       rxs;
    logic       frm_valid, glitch, busy;
    srx_frame_t frm;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (rxs)
    );

    srx_framer #(.OS_RATE(OS_RATE)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .os_tick     (os_tick),
        .rxs         (rxs),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_mp_en   (cfg_mp_en),
        .frm_valid   (frm_valid),
        .frm         (frm),
        .glitch      (glitch),
        .busy        (busy)
    );

    srx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .frm_valid (frm_valid),
        .frm       (frm),
        .glitch    (glitch),
        .busy      (busy),
        .rd_stb    (rd_stb),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    // R11: a pending character always requests service
    a_r11_irq_on_dav: assert property (@(posedge clk) disable iff (rst)
        ($past(frm_valid)) |-> irq);
endmodule

// File: tb/sim_srx_receiver.sv
module sim_srx_receiver;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    srx_receiver u0 (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en),
        .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic v);
        @(negedge clk); rx_line = v;
        repeat (15) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit has_x, input logic xb,
                        input logic stopv);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (has_x) line_bit(xb);
        line_bit(stopv);
        @(negedge clk); rx_line = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] sel, input int hold, input string req,
                      output logic [7:0] v);
        @(negedge clk); rd_sel = sel; rd_stb = 1'b1;
        @(negedge clk); v = rd_data;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(req, rd_data, v);
        end
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R12 rd_data", rd_data, 8'h00);
        chk("R12 irq", {7'b0, irq}, 8'h00);
        rd(2'd1, 0, "R12", v); chk("R12 status0", v, 8'h00);
        rd(2'd3, 0, "R10", v); chk("R10 select3", v, 8'h00);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        send(8'hA5, 0, 1'b0, 1'b1);
        chk("R11 irq on char", {7'b0, irq}, 8'h01);
        rd(2'd1, 0, "R1", v); chk("R1 status0", v, 8'h01);
        rd(2'd0, 0, "R1", v); chk("R1 data", v, 8'hA5);
        rd(2'd1, 0, "R8", v); chk("R8 status0 after data read", v, 8'h00);
        chk("R11 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_parity();
        logic [7:0] v;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h03, 1, 1'b0, 1'b1);
        rd(2'd1, 0, "R3", v); chk("R3 even ok", v, 8'h01);
        rd(2'd0, 0, "R3", v); chk("R3 data", v, 8'h03);
        send(8'h07, 1, 1'b0, 1'b1);
        rd(2'd1, 0, "R3", v); chk("R3 even bad", v, 8'h09);
        rd(2'd0, 0, "R3", v); chk("R3 data2", v, 8'h07);
        rd(2'd1, 0, "R8", v); chk("R8 pe cleared", v, 8'h00);
        cfg_par_odd = 1'b1;
        send(8'h07, 1, 1'b0, 1'b1);
        rd(2'd1, 0, "R3", v); chk("R3 odd ok", v, 8'h01);
        rd(2'd0, 0, "R3", v);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_mp();
        logic [7:0] v;
        cfg_par_en = 1'b1; cfg_mp_en = 1'b1;
        send(8'h42, 1, 1'b1, 1'b1);
        rd(2'd1, 0, "R4", v); chk("R4 marker, no parity", v, 8'h21);
        rd(2'd2, 4, "R9", v); chk("R4 address seen", v, 8'h01);
        rd(2'd2, 0, "R10", v); chk("R10 cleared by read", v, 8'h00);
        rd(2'd0, 0, "R4", v); chk("R4 data", v, 8'h42);
        send(8'h10, 1, 1'b0, 1'b1);
        rd(2'd1, 0, "R4", v); chk("R4 data char", v, 8'h01);
        rd(2'd0, 0, "R4", v); chk("R4 data2", v, 8'h10);
        cfg_par_en = 1'b0; cfg_mp_en = 1'b0;
    endtask

    task automatic t_framing();
        logic [7:0] v;
        send(8'h5A, 0, 1'b0, 1'b0);
        rd(2'd1, 0, "R5", v); chk("R5 framing", v, 8'h05);
        rd(2'd0, 0, "R5", v); chk("R5 data", v, 8'h5A);
        send(8'h00, 0, 1'b0, 1'b0);
        rd(2'd1, 0, "R6", v); chk("R6 break", v, 8'h15);
        rd(2'd0, 0, "R6", v); chk("R6 data", v, 8'h00);
        rd(2'd1, 0, "R8", v); chk("R8 break cleared", v, 8'h00);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send(8'h11, 0, 1'b0, 1'b1);
        rd(2'd1, 0, "R7", v); chk("R7 first char", v, 8'h01);
        send(8'h22, 0, 1'b0, 1'b1);
        rd(2'd0, 0, "R7", v); chk("R7 replaced", v, 8'h22);
        rd(2'd1, 0, "R8", v); chk("R8 overrun kept", v, 8'h02);
        chk("R11 irq on ovr", {7'b0, irq}, 8'h01);
        rd(2'd0, 0, "R8", v);
        rd(2'd1, 0, "R8", v); chk("R8 overrun cleared", v, 8'h00);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk); rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        rd(2'd1, 0, "R2", v); chk("R2 no char", v, 8'h00);
        rd(2'd2, 0, "R2", v); chk("R2 rejected start", v, 8'h02);
        rd(2'd2, 0, "R10", v); chk("R10 clear", v, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_plain();
        t_parity();
        t_mp();
        t_framing();
        t_overrun();
        t_glitch();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule